// File: doc/BRIEF.md
# Sign-Extending Shift Register with Shared Data Port

This block is a right-shifting register of parameterised width (eight stages by default). Its parallel data terminals are shared: they carry input during a parallel load and output at all other times. The port is modelled as three separate vectors. `pin_in` carries the values seen on the pins. `pin_out` carries the values the block would drive. `pin_oe` says when the block drives the pins.

Five operations are available: asynchronous clear, hold, parallel load, logical shift-right with a choice of two serial sources, and arithmetic shift-right. In an arithmetic shift, the first stage keeps its own value, so the sign is copied into the stage next to it. A dedicated serial output always shows the last stage and is never turned off.

The first stage is called stage A and sits on bit 0. The last stage is called stage H and sits on bit `WIDTH-1`. Data moves from bit 0 towards the top bit on each shift, so stage A holds the sign bit.

Top module: `shreg_sext`

## Requirements
- R1: Driving `clr_n` low sets every stage to 0 at once, without waiting for a clock edge. While it stays low, no other input and no clock edge changes the register, whatever the value of `oe_n`.
- R2: With `clr_n` high and `reg_en_n` high, a rising clock edge leaves all stages unchanged.
- R3: With `reg_en_n` low and `ser_par` low, a rising clock edge copies `pin_in` into the register, with `pin_in[0]` going to stage A.
- R4: With `reg_en_n` low, `ser_par` high and `sext_n` high, a rising clock edge moves each stage i into stage i+1. Stage A takes `sin0` when `dsel` is 0 and `sin1` when `dsel` is 1.
- R5: With `reg_en_n` low, `ser_par` high and `sext_n` low, a rising clock edge moves stages A to G up by one and stage A keeps its value. `dsel`, `sin0` and `sin1` have no effect in this mode.
- R6: Every bit of `pin_oe` is 1 exactly when `oe_n` is 0 and the block is not in load mode. Load mode means `reg_en_n` low and `ser_par` low. `pin_out` always equals the register, with stage A on bit 0.
- R7: `oe_n` has no effect on the register contents under any clocked operation.
- R8: `ser_out` always equals stage H (bit `WIDTH-1`) and does not depend on `oe_n`.
- R9: When clear is low while the block is in load mode, the register reads zero and `pin_oe` is all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| reg_en_n | input | 1 | Register enable, active low; high means hold |
| ser_par | input | 1 | 1 = serial shift, 0 = parallel load |
| sext_n | input | 1 | Sign-extend select for shifts, active low |
| dsel | input | 1 | Serial source select: 0 = sin0, 1 = sin1 |
| sin0 | input | 1 | Serial input 0 |
| sin1 | input | 1 | Serial input 1 |
| oe_n | input | 1 | Port output enable, active low |
| pin_in | input | WIDTH | Values present on the shared pins |
| pin_out | output | WIDTH | Values driven onto the shared pins |
| pin_oe | output | WIDTH | Per-pin drive enable |
| ser_out | output | 1 | Serial output, always stage H |

## Verification
Loads use values whose stage A bit is set, so that later arithmetic shifts visibly fill the register with ones and can be told apart from logical shifts fed with zeros. Logical shifts run with `dsel` at both settings, and the two serial inputs are given different values so that a swapped source shows up. During sign-extend steps the serial inputs toggle, which exposes any leakage from them.

Hold steps keep the load-mode pattern on `ser_par` and put a different value on `pin_in`, which separates hold from load. Several steps run with `oe_n` high to confirm that clocked operation continues while the port is off. A separate test drops clear in the middle of a cycle, both during load mode and across clock edges.

// File: rtl/shreg_pkg.sv
// Package shreg_pkg
// Shared operation encoding and the control decode for the sign-extending
// shift register. Assumes all control inputs are active as documented in
// the brief (enables and sign-extend active low).
package shreg_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2,
        OP_SEXT  = 2'd3
    } shop_e;

    // Map the three mode pins onto one clocked operation.
    function automatic shop_e decode_op(input logic en_n,
                                        input logic sp,
                                        input logic sx_n);
        shop_e r;
        if (en_n)       r = OP_HOLD;
        else if (!sp)   r = OP_LOAD;
        else if (!sx_n) r = OP_SEXT;
        else            r = OP_SHIFT;
        return r;
    endfunction

endpackage

// File: rtl/shreg_ctrl.sv
// Module shreg_ctrl
// Decodes the mode pins into an operation code, flags load mode for the
// port direction logic and selects the serial input bit. Purely
// combinational; assumes its inputs are stable around the clock edge.
module shreg_ctrl
    import shreg_pkg::*;
(
    input  logic  reg_en_n,
    input  logic  ser_par,
    input  logic  sext_n,
    input  logic  dsel,
    input  logic  sin0,
    input  logic  sin1,
    output shop_e op,
    output logic  load_mode,
    output logic  ser_bit
);

    // Operation decode, load-mode flag and serial source choice.
    always_comb begin
        op        = decode_op(reg_en_n, ser_par, sext_n);
        load_mode = !reg_en_n && !ser_par;
        ser_bit   = dsel ? sin1 : sin0;
    end

endmodule

// File: rtl/shreg_stage.sv
// Module shreg_stage
// One register stage. It picks its next value from the operation code and
// clears asynchronously on clr_n low. IS_FIRST marks stage A: it takes the
// serial bit on a logical shift and keeps its value on a sign-extend shift.
module shreg_stage
    import shreg_pkg::*;
#(
    parameter bit IS_FIRST = 1'b0
) (
    input  logic  clk,
    input  logic  clr_n,
    input  shop_e op,
    input  logic  prev_bit,
    input  logic  par_bit,
    output logic  q
);

    logic nxt;

    // Next-value selection for this stage.
    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = par_bit;
            OP_SHIFT: nxt = prev_bit;
            OP_SEXT:  nxt = IS_FIRST ? q : prev_bit;
            default:  nxt = q;
        endcase
    end

    // Storage flop with asynchronous active-low clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= 1'b0;
        else        q <= nxt;
    end

endmodule

// File: rtl/shreg_port.sv
// Module shreg_port
// Drives the shared data port and the serial output from the register.
// Assumes the pad itself merges pin_out and pin_oe into a three-state pin.
module shreg_port #(
    parameter int WIDTH = 8
) (
    input  logic             oe_n,
    input  logic             load_mode,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             ser_out
);

    // Port drive: turned off when the pins act as inputs or oe_n is high.
    always_comb begin
        pin_out = q;
        pin_oe  = {WIDTH{!oe_n && !load_mode}};
        ser_out = q[WIDTH-1];
    end

endmodule

// File: rtl/shreg_sext.sv
// Module shreg_sext
// Top level of the sign-extending shift register with a shared data port.
// It assumes stage A is bit 0 and that data moves towards bit WIDTH-1.
// clr_n is an asynchronous clear that the environment releases away from
// the clock edge. The assertions guarding each requirement sit here.
module shreg_sext
    import shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             reg_en_n,
    input  logic             ser_par,
    input  logic             sext_n,
    input  logic             dsel,
    input  logic             sin0,
    input  logic             sin1,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             ser_out
);

    localparam int TOP = WIDTH - 1;

    shop_e            op;
    logic             load_mode;
    logic             ser_bit;
    logic [WIDTH-1:0] q;

    shreg_ctrl u_ctrl (
        .reg_en_n  (reg_en_n),
        .ser_par   (ser_par),
        .sext_n    (sext_n),
        .dsel      (dsel),
        .sin0      (sin0),
        .sin1      (sin1),
        .op        (op),
        .load_mode (load_mode),
        .ser_bit   (ser_bit)
    );

    // One stage per bit; the first stage is fed from the serial input.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            shreg_stage #(.IS_FIRST(1'b1)) u_stage (
                .clk      (clk),
                .clr_n    (clr_n),
                .op       (op),
                .prev_bit (ser_bit),
                .par_bit  (pin_in[i]),
                .q        (q[i])
            );
        end else begin : g_rest
            shreg_stage #(.IS_FIRST(1'b0)) u_stage (
                .clk      (clk),
                .clr_n    (clr_n),
                .op       (op),
                .prev_bit (q[i-1]),
                .par_bit  (pin_in[i]),
                .q        (q[i])
            );
        end
    end

    shreg_port #(.WIDTH(WIDTH)) u_port (
        .oe_n      (oe_n),
        .load_mode (load_mode),
        .q         (q),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .ser_out   (ser_out)
    );

    // R2: a disabled register keeps its value.
    a_r2_hold: assert property (@(posedge clk) disable iff (!clr_n)
        reg_en_n |=> $stable(pin_out));

    // R3: a load captures the shared pins.
    a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
        (!reg_en_n && !ser_par) |=> (pin_out == $past(pin_in)));

    // R4: a logical shift moves the stages up by one and inserts the chosen serial bit.
    a_r4_shift: assert property (@(posedge clk) disable iff (!clr_n)
        (!reg_en_n && ser_par && sext_n) |=>
        (pin_out[TOP:1] == $past(pin_out[TOP-1:0]))
        && (pin_out[0] == ($past(dsel) ? $past(sin1) : $past(sin0))));

    // R5: an arithmetic shift keeps stage A.
    a_r5_sext: assert property (@(posedge clk) disable iff (!clr_n)
        (!reg_en_n && ser_par && !sext_n) |=>
        (pin_out[TOP:1] == $past(pin_out[TOP-1:0]))
        && (pin_out[0] == $past(pin_out[0])));

    // R6: the port is not driven while oe_n is high.
    a_r6_oe_off: assert property (@(posedge clk) disable iff (!clr_n)
        oe_n |-> (pin_oe == '0));

    // R6 / R9: the port is not driven in load mode.
    a_r9_load_hiz: assert property (@(posedge clk) disable iff (!clr_n)
        (!reg_en_n && !ser_par) |-> (pin_oe == '0));

    // R8: the serial output follows the last stage.
    a_r8_serout: assert property (@(posedge clk) disable iff (!clr_n)
        ser_out == pin_out[TOP]);

endmodule

// File: tb/test_shreg_sext.sv
// Bench for shreg_sext. A table of vectors is walked against a bench model,
// then directed tests cover reset and the clear corner cases.
module test_shreg_sext;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n, reg_en_n, ser_par, sext_n, dsel, sin0, sin1, oe_n;
    logic [W-1:0] pin_in, pin_out, pin_oe;
    logic         ser_out;
    logic [W-1:0] m;
    int           n_chk  = 0;
    int           n_fail = 0;
    bit           done   = 1'b0;

    always #2.5 clk = ~clk;

    shreg_sext #(.WIDTH(W)) i_shreg_sext (
        .clk(clk), .clr_n(clr_n), .reg_en_n(reg_en_n), .ser_par(ser_par),
        .sext_n(sext_n), .dsel(dsel), .sin0(sin0), .sin1(sin1), .oe_n(oe_n),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .ser_out(ser_out)
    );

    // Vector layout: en_n sp sx_n ds s0 s1 oe_n _ data[7:0]
    localparam logic [14:0] VECS [0:17] = '{
        15'b0_0_1_0_0_0_0_10010111,  // R3 load, stage A set (negative)
        15'b1_0_1_0_0_0_0_00111100,  // R2 hold, load pattern on sp
        15'b0_1_0_0_1_1_0_00000000,  // R5 sext, serial inputs at 1
        15'b0_1_0_1_0_0_0_11111111,  // R5 sext, dsel flipped
        15'b0_1_0_0_1_0_0_00000000,  // R5 sext
        15'b0_1_1_0_1_0_0_00000000,  // R4 shift from sin0 = 1
        15'b0_1_1_1_1_0_0_00000000,  // R4 shift from sin1 = 0
        15'b0_1_1_1_0_1_0_00000000,  // R4 shift from sin1 = 1
        15'b0_1_1_0_0_1_1_00000000,  // R4 R7 shift, port off
        15'b0_0_1_0_0_0_1_01011010,  // R3 R7 load, port off
        15'b0_1_0_1_1_1_1_00000000,  // R5 R7 sext, port off
        15'b1_1_1_0_0_0_1_11111111,  // R2 R7 hold
        15'b0_0_0_0_0_0_0_00000001,  // R3 load 0x01
        15'b0_1_0_0_0_0_0_00000000,  // R5 sext
        15'b0_1_0_1_0_0_0_00000000,  // R5 sext
        15'b0_1_1_1_0_1_0_00000000,  // R4 shift
        15'b0_0_1_0_0_0_0_10000000,  // R3 load 0x80
        15'b1_0_0_0_0_0_1_00000000   // R2 hold, port off
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [14:0] v);
        {reg_en_n, ser_par, sext_n, dsel, sin0, sin1, oe_n, pin_in} = v;
    endtask

    // Bench model of one rising edge, written from the requirements.
    function automatic logic [W-1:0] model_next(input logic [14:0] v, input logic [W-1:0] cur);
        logic [W-1:0] r;
        r = cur;
        if (!v[14]) begin
            if (!v[13])      r = v[7:0];
            else if (!v[12]) r = {cur[W-2:0], cur[0]};
            else             r = {cur[W-2:0], (v[11] ? v[9] : v[10])};
        end
        return r;
    endfunction

    function automatic string op_tag(input logic [14:0] v);
        if (v[14])      return "R2";
        else if (!v[13]) return "R3";
        else if (!v[12]) return "R5";
        else            return "R4";
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clr_n = 1'b0;
        apply(15'b1_1_1_0_0_0_0_00000000);
        m = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset value", {24'd0, pin_out}, 32'd0);
        check("R8 reset serial", {31'd0, ser_out}, 32'd0);
        clr_n = 1'b1;
        @(negedge clk);

        foreach (VECS[k]) begin
            apply(VECS[k]);
            #1;
            check("R6 drive enable", {24'd0, pin_oe},
                  {24'd0, {W{!VECS[k][8] && !(!VECS[k][14] && !VECS[k][13])}}});
            m = model_next(VECS[k], m);
            @(negedge clk);
            check(op_tag(VECS[k]), {24'd0, pin_out}, {24'd0, m});
            check("R8 serial out", {31'd0, ser_out}, {31'd0, m[W-1]});
        end

        // R1: clear mid-cycle after loading all ones, no clock edge needed
        apply(15'b0_0_1_0_0_0_0_11111111);
        @(negedge clk);
        check("R3 load ones", {24'd0, pin_out}, 32'h0000_00ff);
        #1 clr_n = 1'b0;
        #0.5;
        check("R1 async clear", {24'd0, pin_out}, 32'd0);
        // R9: clear during load mode keeps the port off and the register zero
        check("R9 port off", {24'd0, pin_oe}, 32'd0);
        @(negedge clk);
        check("R9 clear in load", {24'd0, pin_out}, 32'd0);
        // R1 / R7: clear wins over shifting with the port off
        apply(15'b0_1_1_0_1_1_1_00000000);
        repeat (2) @(negedge clk);
        check("R1 clear overrides shift", {24'd0, pin_out}, 32'd0);
        clr_n = 1'b1;
        @(negedge clk);
        check("R4 shift after clear", {24'd0, pin_out}, 32'h0000_0001);
        // R8: serial output stays live with the port off
        apply(15'b0_0_1_0_0_0_1_10000000);
        @(negedge clk);
        check("R8 serial with port off", {31'd0, ser_out}, 32'd1);
        check("R6 port off", {24'd0, pin_oe}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule